// File: doc/BRIEF.md
# Latency-Equalized In-Order Writeback Back End

This block is the execute-to-writeback section of an in-order core. Decoded micro-ops arrive one per cycle with an operation code, a destination register tag, two source register tags, an immediate and a fault flag. Each accepted micro-op reads its operands once, at entry, from the register file or from a forwarding path. It then passes through exactly three execute stages, X1 to X3, before a single shared register write port. The integer unit, the pipelined adder and the pipelined multiplier all take this common depth, so exactly one result can leave per cycle and results always retire in acceptance order.

The integer result is usable from X1 onward. Adder and multiplier results are usable only from X3. A consumer whose producer has not yet reached a usable stage is held by the stall output until forwarding can supply the value. The divider is unpipelined: a divide holds X1 for a configurable number of cycles and blocks issue while it does. X3 is the commit point. A micro-op that arrives there with its fault flag set writes nothing, raises a one-cycle trap pulse, and discards every younger micro-op already accepted.

Top module: `wbp_backend`

## Requirements
- R1: After reset, the stall, write-enable and trap outputs are low, and every architectural register reads as zero.
- R2: Operation code 0 (integer) writes src1 + immediate. Code 1 (adder) writes src1 + src2. Code 2 (multiplier) writes the low XLEN bits of src1 × src2. Code 3 (divider) writes the unsigned quotient src1 / src2, or all ones when src2 is zero. All arithmetic wraps to XLEN bits.
- R3: A non-divide micro-op accepted at clock edge N drives its result on the write port in the cycle after edge N+3.
- R4: Results appear on the write port at most one per cycle, in the order their micro-ops were accepted, and only for micro-ops that were not discarded.
- R5: A micro-op that needs the result of an integer micro-op accepted on the preceding edge is accepted without any stall cycle.
- R6: A micro-op whose source is written by an adder or multiplier micro-op accepted on the preceding edge stalls for exactly 2 cycles. An independent micro-op does not stall.
- R7: A divide occupies X1 for DIV_CYC cycles. The micro-op that follows stalls for DIV_CYC-1 cycles when independent, and for DIV_CYC+1 cycles when it reads the quotient. The quotient reaches the write port DIV_CYC-1 cycles later than a non-divide result would.
- R8: A faulting micro-op accepted at edge N raises the trap output for one cycle after edge N+3, or after edge N+DIV_CYC+2 for a divide, and never writes its destination.
- R9: Every micro-op accepted after a faulting micro-op, up to and including the edge on which the trap is raised, is discarded without a write. Micro-ops accepted later proceed normally.
- R10: Each result uses the operand values current at its acceptance, so the sequence of writes and the final register contents equal those of a one-at-a-time sequential execution of the non-discarded micro-ops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A micro-op is presented |
| in_op | input | 2 | Operation code (see R2) |
| in_dst | input | AW | Destination register tag |
| in_src1 | input | AW | First source register tag |
| in_src2 | input | AW | Second source register tag (unused by code 0) |
| in_imm | input | XLEN | Immediate for code 0 |
| in_exc | input | 1 | The micro-op carries a fault |
| stall_o | output | 1 | Presented micro-op is not accepted this cycle |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | AW | Register written |
| wr_data_o | output | XLEN | Value written |
| trap_o | output | 1 | One-cycle pulse when a fault is taken at commit |

## Verification
The bench builds the block with XLEN=8, NREG=4 and DIV_CYC=3. With only four registers, a random stream keeps hitting read-after-write and write-after-write collisions. The three-cycle divide keeps every hold window short enough to enumerate. These values make it practical to sweep every producer/consumer pairing of the four operation codes against no dependency, a first-source dependency and a second-source dependency, and to check each exact stall count. Eight-bit data makes wrap-around and divide-by-zero show up often in a stream of a few thousand micro-ops, each checked for value, destination and writeback cycle.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  // Operation codes; values are part of the block's interface.
  typedef enum logic [1:0] {
    OP_INT = 2'd0,
    OP_ADD = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } op_e;

  // Number of execute stages every micro-op passes before writeback.
  localparam int NSTG = 3;
endpackage

// File: rtl/wbp_regfile.sv
module wbp_regfile #(
  parameter int XLEN = 16,
  parameter int NREG = 8,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   ra0,
  input  logic [AW-1:0]   ra1,
  output logic [XLEN-1:0] rd0,
  output logic [XLEN-1:0] rd1
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/wbp_units.sv
module wbp_units #(
  parameter int XLEN = 16
) (
  input  wbp_pkg::op_e    op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] res
);
  import wbp_pkg::*;

  logic [2*XLEN-1:0] prod;

  always_comb begin
    prod = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
    unique case (op)
      OP_INT:  res = a + imm;
      OP_ADD:  res = a + b;
      OP_MUL:  res = prod[XLEN-1:0];
      default: res = (b == '0) ? '1 : a / b;
    endcase
  end
endmodule

// File: rtl/wbp_fwd.sv
module wbp_fwd #(
  parameter int XLEN = 16,
  parameter int AW   = 3,
  parameter int NSTG = wbp_pkg::NSTG
) (
  input  logic [AW-1:0]        src,
  input  logic [XLEN-1:0]      rf_val,
  input  logic [NSTG-1:0]      stg_v,
  input  logic [NSTG-1:0]      stg_rdy,
  input  logic [NSTG*AW-1:0]   stg_dst,
  input  logic [NSTG*XLEN-1:0] stg_dat,
  output logic [XLEN-1:0]      val,
  output logic                 busy
);
  // Oldest stage first, so the youngest matching producer wins.
  always_comb begin
    val  = rf_val;
    busy = 1'b0;
    for (int s = NSTG - 1; s >= 0; s--) begin
      if (stg_v[s] && (stg_dst[s*AW +: AW] == src)) begin
        val  = stg_dat[s*XLEN +: XLEN];
        busy = !stg_rdy[s];
      end
    end
  end
endmodule

// File: rtl/wbp_backend.sv
module wbp_backend #(
  parameter int XLEN    = 16,
  parameter int NREG    = 8,
  parameter int DIV_CYC = 4,
  localparam int AW = $clog2(NREG),
  localparam int CW = $clog2(DIV_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic [AW-1:0]   in_dst,
  input  logic [AW-1:0]   in_src1,
  input  logic [AW-1:0]   in_src2,
  input  logic [XLEN-1:0] in_imm,
  input  logic            in_exc,
  output logic            stall_o,
  output logic            wr_en_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [XLEN-1:0] wr_data_o,
  output logic            trap_o
);
  import wbp_pkg::*;

  localparam int NS   = wbp_pkg::NSTG;
  localparam int LAST = NS - 1;

  // Execute stage state; index 0 is X1, LAST is the commit stage.
  logic [NS-1:0]   st_v;
  logic [NS-1:0]   st_rdy;
  logic [NS-1:0]   st_exc;
  logic [AW-1:0]   st_dst [NS];
  logic [XLEN-1:0] st_dat [NS];
  op_e             x1_op;
  logic [CW-1:0]   div_cnt;

  logic [NS*AW-1:0]   dst_flat;
  logic [NS*XLEN-1:0] dat_flat;

  op_e             iop;
  logic [AW-1:0]   src_tag [2];
  logic [XLEN-1:0] rf_val  [2];
  logic [XLEN-1:0] opnd    [2];
  logic [1:0]      src_wait;
  logic [XLEN-1:0] res;
  logic            uses2, raw, div_hold, adv1, accept, flush, rf_we;

  assign iop        = op_e'(in_op);
  assign src_tag[0] = in_src1;
  assign src_tag[1] = in_src2;

  assign flush    = st_v[LAST] & st_exc[LAST];
  assign rf_we    = st_v[LAST] & ~st_exc[LAST];
  assign div_hold = st_v[0] && (x1_op == OP_DIV) && (div_cnt != '0);
  assign adv1     = !div_hold;
  assign uses2    = (iop != OP_INT);
  assign raw      = src_wait[0] | (src_wait[1] & uses2);
  assign stall_o  = div_hold | (in_valid & raw);
  assign accept   = in_valid & ~stall_o;

  wbp_regfile #(.XLEN(XLEN), .NREG(NREG)) i_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (st_dst[LAST]),
    .wdata (st_dat[LAST]),
    .ra0   (in_src1),
    .ra1   (in_src2),
    .rd0   (rf_val[0]),
    .rd1   (rf_val[1])
  );

  genvar g;
  for (g = 0; g < NS; g++) begin : g_flat
    assign dst_flat[g*AW +: AW]     = st_dst[g];
    assign dat_flat[g*XLEN +: XLEN] = st_dat[g];
  end

  for (g = 0; g < 2; g++) begin : g_src
    wbp_fwd #(.XLEN(XLEN), .AW(AW), .NSTG(NS)) i_fwd (
      .src     (src_tag[g]),
      .rf_val  (rf_val[g]),
      .stg_v   (st_v),
      .stg_rdy (st_rdy),
      .stg_dst (dst_flat),
      .stg_dat (dat_flat),
      .val     (opnd[g]),
      .busy    (src_wait[g])
    );
  end

  wbp_units #(.XLEN(XLEN)) i_units (
    .op  (iop),
    .a   (opnd[0]),
    .b   (opnd[1]),
    .imm (in_imm),
    .res (res)
  );

  // Control state with reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_v    <= '0;
      div_cnt <= '0;
      wr_en_o <= 1'b0;
      trap_o  <= 1'b0;
    end else begin
      wr_en_o <= rf_we;
      trap_o  <= flush;
      for (int s = 1; s < NS; s++) begin
        st_v[s] <= st_v[s-1] & ((s != 1) | adv1) & ~flush;
      end
      if (flush) begin
        st_v[0] <= 1'b0;
        div_cnt <= '0;
      end else if (adv1) begin
        st_v[0] <= accept;
        div_cnt <= (accept && (iop == OP_DIV)) ? CW'(DIV_CYC - 1) : '0;
      end else begin
        div_cnt <= div_cnt - CW'(1);
      end
    end
  end

  // Datapath registers, no reset; qualified by the valid bits.
  always_ff @(posedge clk) begin
    wr_addr_o <= st_dst[LAST];
    wr_data_o <= st_dat[LAST];
    for (int s = 1; s < NS; s++) begin
      st_dst[s] <= st_dst[s-1];
      st_dat[s] <= st_dat[s-1];
      st_exc[s] <= st_exc[s-1];
      st_rdy[s] <= st_rdy[s-1] | (s == LAST);
    end
    if (adv1) begin
      x1_op     <= iop;
      st_dst[0] <= in_dst;
      st_dat[0] <= res;
      st_exc[0] <= in_exc;
      st_rdy[0] <= (iop == OP_INT);
    end
  end

  // R7: a divide with cycles left stays in X1 unless flushed.
  a_r7_x1_hold: assert property (@(posedge clk) disable iff (rst)
    (div_hold && !flush) |=> (st_v[0] && (x1_op == OP_DIV)));

  // R7: the divide countdown never exceeds its configured length.
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    div_cnt <= CW'(DIV_CYC - 1));

  // R9: a commit-stage fault leaves no younger micro-op in flight.
  a_r9_flush_drains: assert property (@(posedge clk) disable iff (rst)
    flush |=> (st_v == '0));

  // R8: the trap cycle carries no register write.
  a_r8_trap_no_write: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> !wr_en_o);

  // R3: a write only follows an occupied commit stage.
  a_r3_write_from_last: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> $past(st_v[LAST]));
endmodule

// File: tb/test_wbp_backend.sv
module test_wbp_backend;
  localparam int XLEN    = 8;
  localparam int NREG    = 4;
  localparam int DIV_CYC = 3;
  localparam int AW      = $clog2(NREG);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [1:0]      in_op = '0;
  logic [AW-1:0]   in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [XLEN-1:0] in_imm = '0;
  logic            in_exc = 1'b0;
  logic            stall_o, wr_en_o, trap_o;
  logic [AW-1:0]   wr_addr_o;
  logic [XLEN-1:0] wr_data_o;

  always #4 clk = ~clk;

  wbp_backend #(.XLEN(XLEN), .NREG(NREG), .DIV_CYC(DIV_CYC)) i_wbp_backend (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
    .in_src1(in_src1), .in_src2(in_src2), .in_imm(in_imm), .in_exc(in_exc),
    .stall_o(stall_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .trap_o(trap_o)
  );

  int n_checks = 0, n_fail = 0, cyc = 0, wd = 0;
  bit acc = 1'b0, kill = 1'b0;
  int a_op, a_d, a_s1, a_s2, a_imm, a_ex;
  int exp_trap = -1, n_killed = 0, n_traps = 0;
  int ea, ed, ec, lat;
  logic [XLEN-1:0] r, ref_rf [NREG], shadow [NREG];
  int qa[$], qd[$], qc[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  function automatic logic [XLEN-1:0] model(input int op, input logic [XLEN-1:0] a,
                                           input logic [XLEN-1:0] b, input logic [XLEN-1:0] imm);
    logic [2*XLEN-1:0] p;
    p = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
    case (op)
      0:       return a + imm;
      1:       return a + b;
      2:       return p[XLEN-1:0];
      default: return (b == '0) ? '1 : a / b;
    endcase
  endfunction

  // Present one micro-op; returns the number of stall cycles seen.
  task automatic send(input int op, input int d, input int s1, input int s2,
                      input int imm, input int ex, output int nst);
    nst = 0;
    @(negedge clk); #2;
    in_valid = 1'b1; in_op = 2'(op); in_dst = AW'(d);
    in_src1 = AW'(s1); in_src2 = AW'(s2); in_imm = XLEN'(imm); in_exc = ex[0];
    #1;
    while (stall_o) begin
      nst++;
      @(negedge clk); #3;
    end
    acc = 1'b1; a_op = op; a_d = d; a_s1 = s1; a_s2 = s2; a_imm = imm; a_ex = ex;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk); #2;
      in_valid = 1'b0;
    end
  endtask

  // Reference model and write-port scoreboard, evaluated mid-cycle.
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (wr_en_o) begin
        if (qa.size() == 0) begin
          check(1'b0, "R4 write with nothing pending", int'(wr_addr_o), -1);
        end else begin
          ea = qa.pop_front(); ed = qd.pop_front(); ec = qc.pop_front();
          check(int'(wr_addr_o) == ea, "R4 write order destination", int'(wr_addr_o), ea);
          check(wr_data_o == XLEN'(ed), "R2 R10 written value", int'(wr_data_o), ed);
          check(cyc == ec, "R3 R7 writeback cycle", cyc, ec);
        end
        shadow[wr_addr_o] = wr_data_o;
      end
      if (acc) begin
        acc = 1'b0;
        lat = (a_op == 3) ? DIV_CYC + 2 : 3;
        if (kill) begin
          n_killed++;                       // R9: discarded younger micro-op
        end else if (a_ex != 0) begin
          kill = 1'b1;
          exp_trap = cyc + lat;
        end else begin
          r = model(a_op, ref_rf[a_s1], ref_rf[a_s2], XLEN'(a_imm));
          ref_rf[a_d] = r;
          qa.push_back(a_d); qd.push_back(int'(r)); qc.push_back(cyc + lat);
        end
      end
      if (trap_o) begin
        check(cyc == exp_trap, "R8 trap timing", cyc, exp_trap);
        n_traps++;
        kill = 1'b0;
        exp_trap = -1;
      end else if (exp_trap == cyc) begin
        check(1'b0, "R8 trap missing", 0, exp_trap);
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", wd, 150000);
      summary();
    end
  end

  initial begin
    int ns, e, kb, tb, v1;
    bit d_eff;
    for (int i = 0; i < NREG; i++) begin ref_rf[i] = '0; shadow[i] = '0; end
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    check(stall_o == 1'b0, "R1 stall low after reset", int'(stall_o), 0);
    check(wr_en_o == 1'b0, "R1 no write after reset", int'(wr_en_o), 0);
    check(trap_o == 1'b0, "R1 no trap after reset", int'(trap_o), 0);

    // R1: an adder op over untouched registers must write zero.
    send(1, 0, 1, 2, 0, 0, ns);
    idle(6);
    check(shadow[0] == '0, "R1 registers zero after reset", int'(shadow[0]), 0);

    for (int i = 0; i < NREG; i++) send(0, i, i, 0, i * 37 + 11, 0, ns);
    idle(6);

    // Producer/consumer sweep: R5, R6, R7 stall counts.
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 4; c++)
        for (int dep = 0; dep < 3; dep++) begin
          idle(DIV_CYC + 6);
          send(p, 1, 2, 3, 5, 0, ns);
          send(c, 0, (dep == 1) ? 1 : 2, (dep == 2) ? 1 : 3, 9, 0, ns);
          d_eff = (dep == 1) || (dep == 2 && c != 0);
          if (p == 3)             e = d_eff ? DIV_CYC + 1 : DIV_CYC - 1;
          else if (d_eff && p != 0) e = 2;
          else                     e = 0;
          if (p == 3)      check(ns == e, "R7 divide stall", ns, e);
          else if (p == 0) check(ns == e, "R5 integer forwarding", ns, e);
          else             check(ns == e, "R6 long-op stall", ns, e);
        end
    idle(DIV_CYC + 6);

    // R2: divide by zero gives all ones.
    send(0, 3, 3, 0, int'(-ref_rf[3]), 0, ns);
    send(3, 2, 1, 3, 0, 0, ns);
    idle(DIV_CYC + 6);
    check(shadow[2] == '1, "R2 divide by zero", int'(shadow[2]), (1 << XLEN) - 1);

    // R10: operands captured at acceptance despite a younger overwrite.
    v1 = int'(ref_rf[1]);
    send(1, 2, 1, 1, 0, 0, ns);
    send(0, 1, 1, 0, 3, 0, ns);
    idle(6);
    check(shadow[2] == XLEN'(2 * v1), "R10 operand capture", int'(shadow[2]), (2 * v1) % (1 << XLEN));

    // R8, R9: faulting adder followed by four independent integer ops.
    kb = n_killed; tb = n_traps;
    send(1, 2, 1, 1, 0, 1, ns);
    for (int k = 0; k < 4; k++) send(0, 3, 0, 0, k + 1, 0, ns);
    idle(10);
    check(n_traps - tb == 1, "R8 one trap taken", n_traps - tb, 1);
    check(n_killed - kb == 3, "R9 younger ops discarded", n_killed - kb, 3);
    check(shadow[2] == ref_rf[2], "R8 faulting op wrote nothing", int'(shadow[2]), int'(ref_rf[2]));
    check(shadow[3] == ref_rf[3], "R9 later op survives", int'(shadow[3]), int'(ref_rf[3]));

    // R8: faulting divide, trap timing checked by the monitor.
    tb = n_traps;
    send(3, 2, 1, 1, 0, 1, ns);
    idle(DIV_CYC + 8);
    check(n_traps - tb == 1, "R8 divide trap taken", n_traps - tb, 1);

    // Random stream against the sequential model.
    for (int i = 0; i < 2500; i++) begin
      send(int'($urandom_range(3)), int'($urandom_range(NREG - 1)),
           int'($urandom_range(NREG - 1)), int'($urandom_range(NREG - 1)),
           int'($urandom_range((1 << XLEN) - 1)), ($urandom_range(15) == 0) ? 1 : 0, ns);
      if ($urandom_range(3) == 0) idle(int'($urandom_range(3)) + 1);
    end
    idle(DIV_CYC + 10);
    check(qa.size() == 0, "R4 all results retired", qa.size(), 0);
    for (int i = 0; i < NREG; i++)
      check(shadow[i] == ref_rf[i], "R10 final register state", int'(shadow[i]), int'(ref_rf[i]));
    summary();
  end
endmodule